// File: doc/BRIEF.md
# Dual Periodic Reload Timer

This block holds two independent periodic down-counters that share one slow tick enable, nominally 32768 ticks per second. Software programs each counter through a 16-bit synchronous register port. It writes a 32-bit reload value as two 16-bit halves and can read the running count back as two halves. While its reload value is nonzero, a counter steps down once per tick. When it expires it raises a sticky flag in a shared status word and starts the next period from its reload value on its own.

Each flag is cleared by writing a one to its bit position; writing a zero leaves it alone. An interrupt enable word gates each flag onto its own interrupt line. A reload of zero parks the counter. Reloads below five are raised to five, which caps the expiry rate at about 6.5 kHz.

The register port is a plain synchronous one. A write takes effect at the clock edge on which `reg_wr` is high. Read data is combinational from `reg_addr`. There is no stream traffic, so the port has no valid/ready handshake and never applies back-pressure.

Top module: `prt_timer_pair`

## Requirements
- R1: After reset, every register reads 0: both reload values, both counts, the status word and the enable word. Both interrupt outputs are low.
- R2: Register offsets are byte addresses. Timer A has its reload at 0x10 (bits 15:0) and 0x12 (bits 31:16), and its count at 0x14 (low) and 0x16 (high). Timer B has its reload at 0x18 and 0x1A, and its count at 0x1C and 0x1E. Reload words read back as written.
- R3: While the effective reload is zero, a tick drives the count to 0 and raises no flag.
- R4: A write to either reload word of a timer freezes that timer for the write cycle. On the first tick after the write, the count loads the new effective reload, with no expiry.
- R5: Without a tick, a count does not change.
- R6: On a tick where the count is 1 (or 0) and the effective reload is nonzero, the timer sets its flag and reloads in that same cycle. Otherwise a tick decrements the count, so flags repeat every reload-value ticks.
- R7: A nonzero reload below 5 behaves as 5.
- R8: The status word sits at 0x20. Bit 1 is timer A's flag and bit 2 is timer B's flag; all other bits read 0. Writing 1 to a flag bit clears only that flag, and writing 0 has no effect.
- R9: If a flag's expiry and its clear fall in the same cycle, the flag ends up set.
- R10: The enable word sits at 0x22, with bit 1 for timer A and bit 2 for timer B. `irq_out[0]` is timer A's flag AND its enable, and `irq_out[1]` is timer B's flag AND its enable.
- R11: The timers are independent. Writes and expiries of one never alter the other's count or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count tick (32768 Hz rate) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq_out | output | 2 | Gated expiry interrupts, bit 0 timer A, bit 1 timer B |

## Verification
Two pairs of functions can fall in the same cycle. The first is a timer's expiry against a software clear of the same flag. The bench runs timer A to a count of 1, already holding a set flag, then raises the tick together with a write of 0x02 to the status word. The flag must still read set afterwards, and the count must be back at the full period. The second is a reload write in a tick cycle against the other timer's counting: the untouched timer's count must keep stepping while the written timer holds.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned N_TIMERS  = 2;
  localparam int unsigned T_STRIDE  = 8;
  localparam logic [ADDR_W-1:0] A_TBASE  = 6'h10;
  localparam logic [ADDR_W-1:0] A_STATUS = 6'h20;
  localparam logic [ADDR_W-1:0] A_IRQEN  = 6'h22;
  localparam logic [ADDR_W-1:0] OFS_RL_LO  = 6'h0;
  localparam logic [ADDR_W-1:0] OFS_RL_HI  = 6'h2;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 6'h4;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 6'h6;

  function automatic logic [ADDR_W-1:0] timer_base(input int unsigned idx);
    return A_TBASE + ADDR_W'(idx * T_STRIDE);
  endfunction
endpackage

// File: rtl/prt_reload_counter.sv
module prt_reload_counter
  import prt_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned MIN_RELOAD = 5,
  parameter logic [ADDR_W-1:0] BASE = 6'h10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     wdata,
  output logic [2*WORD_W-1:0]   reload_q,
  output logic [2*WORD_W-1:0]   cnt_q,
  output logic                  expire
);
  localparam int unsigned CNT_W = 2 * WORD_W;

  logic              wr_lo, wr_hi, wr_any;
  logic              pend_q;
  logic [CNT_W-1:0]  eff_reload;
  logic              at_end;

  assign wr_lo  = wr && (addr == BASE + OFS_RL_LO);
  assign wr_hi  = wr && (addr == BASE + OFS_RL_HI);
  assign wr_any = wr_lo || wr_hi;

  always_comb begin
    if (reload_q == '0)
      eff_reload = '0;
    else if (reload_q < CNT_W'(MIN_RELOAD))
      eff_reload = CNT_W'(MIN_RELOAD);
    else
      eff_reload = reload_q;
  end

  assign at_end = (cnt_q <= CNT_W'(1));
  assign expire = tick_en && !wr_any && !pend_q && (eff_reload != '0) && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (wr_lo) reload_q[WORD_W-1:0]     <= wdata;
      if (wr_hi) reload_q[CNT_W-1:WORD_W] <= wdata;
      if (wr_any) begin
        pend_q <= 1'b1;
      end else if (tick_en) begin
        if (pend_q) begin
          cnt_q  <= eff_reload;
          pend_q <= 1'b0;
        end else if (eff_reload == '0) begin
          cnt_q <= '0;
        end else if (at_end) begin
          cnt_q <= eff_reload;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/prt_irq_status.sv
module prt_irq_status
  import prt_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_TIMERS-1:0]   expire,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     wdata,
  output logic [WORD_W-1:0]     status_word,
  output logic [WORD_W-1:0]     enable_word,
  output logic [N_TIMERS-1:0]   irq
);
  logic [N_TIMERS-1:0] flag_q;
  logic [N_TIMERS-1:0] en_q;
  logic                wr_status, wr_enable;

  assign wr_status = wr && (addr == A_STATUS);
  assign wr_enable = wr && (addr == A_IRQEN);

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        if (expire[i])
          flag_q[i] <= 1'b1;
        else if (wr_status && wdata[i+1])
          flag_q[i] <= 1'b0;
        if (wr_enable)
          en_q[i] <= wdata[i+1];
      end
    end
    assign irq[i] = flag_q[i] & en_q[i];
  end

  always_comb begin
    status_word = '0;
    enable_word = '0;
    for (int i = 0; i < N_TIMERS; i++) begin
      status_word[i+1] = flag_q[i];
      enable_word[i+1] = en_q[i];
    end
  end
endmodule

// File: rtl/prt_read_mux.sv
module prt_read_mux
  import prt_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [N_TIMERS-1:0][2*WORD_W-1:0]   reload,
  input  logic [N_TIMERS-1:0][2*WORD_W-1:0]   cnt,
  input  logic [WORD_W-1:0]                   status_word,
  input  logic [WORD_W-1:0]                   enable_word,
  output logic [WORD_W-1:0]                   rdata
);
  always_comb begin
    rdata = '0;
    if (addr == A_STATUS) rdata = status_word;
    if (addr == A_IRQEN)  rdata = enable_word;
    for (int i = 0; i < N_TIMERS; i++) begin
      if (addr == timer_base(i) + OFS_RL_LO)  rdata = reload[i][WORD_W-1:0];
      if (addr == timer_base(i) + OFS_RL_HI)  rdata = reload[i][2*WORD_W-1:WORD_W];
      if (addr == timer_base(i) + OFS_CNT_LO) rdata = cnt[i][WORD_W-1:0];
      if (addr == timer_base(i) + OFS_CNT_HI) rdata = cnt[i][2*WORD_W-1:WORD_W];
    end
  end
endmodule

// File: rtl/prt_timer_pair.sv
module prt_timer_pair
  import prt_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned MIN_RELOAD = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic [N_TIMERS-1:0]  irq_out
);
  localparam int unsigned CNT_W = 2 * WORD_W;

  logic [N_TIMERS-1:0][CNT_W-1:0] reload_q;
  logic [N_TIMERS-1:0][CNT_W-1:0] cnt_q;
  logic [N_TIMERS-1:0]            expire;
  logic [WORD_W-1:0]              status_word;
  logic [WORD_W-1:0]              enable_word;

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
    prt_reload_counter #(
      .WORD_W(WORD_W), .MIN_RELOAD(MIN_RELOAD), .BASE(timer_base(i))
    ) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .reload_q(reload_q[i]), .cnt_q(cnt_q[i]), .expire(expire[i])
    );
  end

  prt_irq_status #(.WORD_W(WORD_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .expire(expire),
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status_word(status_word), .enable_word(enable_word), .irq(irq_out)
  );

  prt_read_mux #(.WORD_W(WORD_W)) u_rd (
    .addr(reg_addr), .reload(reload_q), .cnt(cnt_q),
    .status_word(status_word), .enable_word(enable_word), .rdata(reg_rdata)
  );
endmodule

// File: rtl/prt_timer_pair_chk.sv
module prt_timer_pair_chk
  import prt_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned MIN_RELOAD = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick_en,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [WORD_W-1:0]    reg_wdata,
  input logic [N_TIMERS-1:0]  irq_out,
  input logic [2*WORD_W-1:0]  cnt_a,
  input logic [2*WORD_W-1:0]  cnt_b,
  input logic [N_TIMERS-1:0]  exp_vec,
  input logic [WORD_W-1:0]    st_word
);
  // R5: no tick and no write -> both counts hold
  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !reg_wr) |=> ($stable(cnt_a) && $stable(cnt_b)));

  // R6: expiry raises the matching flag on the next cycle
  a_r6_flag_a_set: assert property (@(posedge clk) disable iff (!rst_n)
    exp_vec[0] |=> st_word[1]);
  a_r6_flag_b_set: assert property (@(posedge clk) disable iff (!rst_n)
    exp_vec[1] |=> st_word[2]);

  // R7: after an expiry the reloaded count is at least the floor
  a_r7_reload_floor: assert property (@(posedge clk) disable iff (!rst_n)
    exp_vec[0] |=> (cnt_a >= (2*WORD_W)'(MIN_RELOAD)));

  // R8: a clear with no competing expiry drops the flag
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STATUS && reg_wdata[1] && !exp_vec[0]) |=> !st_word[1]);

  // R9: expiry beats a clear in the same cycle
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STATUS && reg_wdata[2] && exp_vec[1]) |=> st_word[2]);

  // R10: an interrupt line is never high without its flag
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out[0] |-> st_word[1]) and (irq_out[1] |-> st_word[2]));
endmodule

bind prt_timer_pair prt_timer_pair_chk #(.WORD_W(WORD_W), .MIN_RELOAD(MIN_RELOAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_out(irq_out),
  .cnt_a(cnt_q[0]), .cnt_b(cnt_q[1]), .exp_vec(expire), .st_word(status_word)
);

// File: tb/sim_prt_timer_pair.sv
module sim_prt_timer_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  irq_out;

  int total = 0;
  int bad = 0;

  localparam int NVEC = 5;
  localparam logic [31:0] RL_TAB  [NVEC] = '{32'd1, 32'd4, 32'd5, 32'd7, 32'd20};
  localparam logic [31:0] PER_TAB [NVEC] = '{32'd5, 32'd5, 32'd5, 32'd7, 32'd20};

  always #2.5 clk = ~clk;

  prt_timer_pair u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(6'h10, v); check("R1 reload A", {16'h0, v}, 0);
    rd(6'h14, v); check("R1 count A", {16'h0, v}, 0);
    rd(6'h1C, v); check("R1 count B", {16'h0, v}, 0);
    rd(6'h20, v); check("R1 status", {16'h0, v}, 0);
    rd(6'h22, v); check("R1 enable", {16'h0, v}, 0);
    check("R1 irq", {30'h0, irq_out}, 0);

    // R3 idle with zero reload
    tick(3);
    rd(6'h1C, v); check("R3 idle count B", {16'h0, v}, 0);
    rd(6'h20, v); check("R3 no flag", {16'h0, v}, 0);

    // Vector table: reload value vs expected period (R6, R7, R2, R4)
    for (int k = 0; k < NVEC; k++) begin
      wr(6'h12, RL_TAB[k][31:16]);
      wr(6'h10, RL_TAB[k][15:0]);
      wr(6'h20, 16'h0006);
      rd(6'h10, v); check("R2 reload readback", {16'h0, v}, {16'h0, RL_TAB[k][15:0]});
      tick(1);
      rd(6'h14, v); check("R4/R7 loaded count", {16'h0, v}, PER_TAB[k]);
      tick(int'(PER_TAB[k]) - 1);
      rd(6'h20, v); check("R6 no early flag", {16'h0, v & 16'h0002}, 0);
      tick(1);
      rd(6'h20, v); check("R6 flag at period", {16'h0, v & 16'h0002}, 2);
      rd(6'h14, v); check("R6 reloaded", {16'h0, v}, PER_TAB[k]);
    end

    // R5 no tick: count holds
    rd(6'h14, v);
    repeat (4) @(negedge clk);
    rd(6'h14, v2); check("R5 hold", {16'h0, v2}, {16'h0, v});

    // R2 high word on timer B, R11 independence, R4 freeze
    wr(6'h1A, 16'h0001);
    wr(6'h18, 16'h0000);
    tick(1);
    rd(6'h1E, v); check("R2 count B high", {16'h0, v}, 1);
    rd(6'h1C, v); check("R2 count B low", {16'h0, v}, 0);
    tick(2);
    rd(6'h1C, v); check("R6 B decrement", {16'h0, v}, 32'hFFFE);
    rd(6'h14, v);
    @(negedge clk);
    tick_en = 1'b1; reg_wr = 1'b1; reg_addr = 6'h10; reg_wdata = 16'd9;
    @(negedge clk);
    tick_en = 1'b0; reg_wr = 1'b0;
    rd(6'h14, v2); check("R4 freeze on write", {16'h0, v2}, {16'h0, v});
    rd(6'h1C, v); check("R11 B keeps counting", {16'h0, v}, 32'hFFFD);
    tick(1);
    rd(6'h14, v); check("R4 load new reload", {16'h0, v}, 9);

    // R9 expiry and clear in the same cycle
    wr(6'h10, 16'd5);
    wr(6'h20, 16'h0006);
    tick(1);
    tick(5);
    rd(6'h20, v); check("R6 flag A", {16'h0, v & 16'h0002}, 2);
    tick(4);
    rd(6'h14, v); check("R6 count at 1", {16'h0, v}, 1);
    @(negedge clk);
    tick_en = 1'b1; reg_wr = 1'b1; reg_addr = 6'h20; reg_wdata = 16'h0002;
    @(negedge clk);
    tick_en = 1'b0; reg_wr = 1'b0;
    rd(6'h20, v); check("R9 set wins", {16'h0, v & 16'h0002}, 2);
    rd(6'h14, v); check("R9 reloaded", {16'h0, v}, 5);

    // R8 zero write no effect, reserved bits zero
    wr(6'h20, 16'h0000);
    rd(6'h20, v); check("R8 zero write", {16'h0, v & 16'h0002}, 2);
    check("R8 reserved bits", {16'h0, v & 16'hFFF9}, 0);

    // R10 interrupt gating
    check("R10 masked", {30'h0, irq_out}, 0);
    wr(6'h22, 16'h0002);
    #1; check("R10 irq A", {30'h0, irq_out}, 1);
    rd(6'h22, v); check("R10 enable readback", {16'h0, v}, 2);
    wr(6'h20, 16'h0002);
    #1; check("R8/R10 cleared", {30'h0, irq_out}, 0);
    rd(6'h20, v); check("R8 flag A cleared", {16'h0, v & 16'h0002}, 0);

    // R3 stop a running timer
    wr(6'h10, 16'h0000);
    tick(1);
    rd(6'h14, v); check("R3 stopped count", {16'h0, v}, 0);
    tick(10);
    rd(6'h20, v); check("R3 no flag stopped", {16'h0, v & 16'h0002}, 0);

    // R11 timer B expiry sets only its bit
    wr(6'h1A, 16'h0000);
    wr(6'h18, 16'd6);
    wr(6'h22, 16'h0006);
    tick(7);
    rd(6'h20, v); check("R11 only B flag", {16'h0, v & 16'h0006}, 4);
    #1; check("R10 irq B", {30'h0, irq_out}, 2);

    finish_run();
  end
endmodule